// File: doc/BRIEF.md
# Serial Value-Checked Transaction Commit Engine

This block finishes transactions that ran speculatively against a shared word-addressed memory. A client streams one transaction into it as a sequence of log beats. Read-entry beats carry a word address and the value the transaction saw there. Write-entry beats carry a word address and the value it wants to store. The engine keeps both logs in local storage. It reads each logged address back from shared memory and compares the current word with the logged value. If every word still matches, the engine writes the buffered stores to memory in log order and reports success. If any word differs, it drops the stores and reports a conflict. A conflict report says only that some word changed, not which other agent changed it.

Only one transaction is in the engine at a time. A new transaction cannot enter until the previous response has been taken. Transactions are therefore checked and committed strictly in arrival order, and the check and the write-back of one transaction never overlap with another. Both logs have a bounded length set by parameters. A transaction that exceeds either bound is answered with an overflow code and does not touch memory.

The memory port issues one access per cycle. A read is issued with `mem_req` high and `mem_we` low. Its data comes back in a later cycle with `mem_rvalid`, and the engine keeps only one read outstanding. A write is issued with `mem_req` and `mem_we` both high, and memory takes it in the same cycle.

Top module: `txn_commit_unit`

## Requirements
- R1: A beat is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_kind` 0 marks a read-log entry and 1 marks a write-log entry, and the two kinds may be interleaved. The beat with `req_last` high ends the transaction. Buffered stores are not visible in memory while the transaction is being validated.
- R2: Validation issues one read per read-log entry, in log order, with at most one read outstanding, and compares each returned word with the logged value.
- R3: On the first mismatch, validation stops at once. No further read is issued, no write is issued, and the response status is 1 (conflict).
- R4: If all read-log words match, every write-log entry is written to memory in log order and the response status is 0 (pass).
- R5: When the write log holds two entries for the same address, memory ends up holding the value of the later entry.
- R6: A transaction with an empty write log that passes validation responds with status 0 and issues no write.
- R7: A transaction with more than `RD_DEPTH` read entries or more than `WR_DEPTH` write entries responds with status 2 (overflow) and issues no memory access at all.
- R8: `req_ready` is low from the acceptance of a last beat until the response handshake completes. No memory access is issued while `req_ready` is high.
- R9: Once `rsp_valid` rises, it stays high and `rsp_status` stays unchanged until a cycle with `rsp_ready` high.
- R10: After reset, `req_ready` is high, and `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Log beat present |
| req_ready | output | 1 | Engine accepts a log beat |
| req_kind | input | 1 | 0 read-log entry, 1 write-log entry |
| req_addr | input | ADDR_W | Word address of the entry |
| req_data | input | DATA_W | Observed value (read) or value to store (write) |
| req_last | input | 1 | Final beat of the transaction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DATA_W | Read data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_status | output | 2 | 0 pass, 1 conflict, 2 overflow |

## Verification
On every cycle the assertions enforce the handshake rules. They check that the request side and the response side are never open together, that no memory access happens while the engine is accepting beats, that reads are issued one at a time, and that a pending response does not change. Through per-transaction flags they also check that a conflict response never follows a write and that an overflow response never follows any memory access. Whether the values are right can only be shown by the bench's scenarios. These cover final memory contents after a commit, the later-wins rule for duplicate addresses, the exact read count at which a conflict stops validation, and the fact that buffered stores stay invisible during validation.

// File: rtl/txn_commit_pkg.sv
package txn_commit_pkg;

    parameter int unsigned ADDR_W = 8;
    parameter int unsigned DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } log_entry_t;

    typedef enum logic [1:0] {
        ST_PASS     = 2'd0,
        ST_CONFLICT = 2'd1,
        ST_OVERFLOW = 2'd2
    } txn_status_e;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_VALIDATE  = 2'd1,
        PH_WRITEBACK = 2'd2,
        PH_RESPOND   = 2'd3
    } phase_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txn_log_store.sv
module txn_log_store
    import txn_commit_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  log_entry_t       push_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output log_entry_t       rd_entry,
    output logic [IDX_W-1:0] count,
    output logic             overflow
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] FULL = IDX_W'(DEPTH);

    log_entry_t       slots_q [DEPTH];
    logic [IDX_W-1:0] count_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (push) begin
            if (count_q < FULL) begin
                slots_q[count_q[PTR_W-1:0]] <= push_entry;
                count_q <= count_q + 1'b1;
            end else begin
                ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (rd_idx < FULL) rd_entry = slots_q[rd_idx[PTR_W-1:0]];
        else               rd_entry = '0;
    end

    assign count    = count_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/txn_commit_ctrl.sv
module txn_commit_ctrl
    import txn_commit_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic              beat_last,
    input  logic [IDX_W-1:0]  rd_cnt,
    input  logic [IDX_W-1:0]  wr_cnt,
    input  logic              rd_ovf,
    input  logic              wr_ovf,
    input  log_entry_t        rd_entry,
    input  log_entry_t        wr_entry,
    output logic [IDX_W-1:0]  idx,
    output logic              accept,
    output logic              clr_logs,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output txn_status_e       rsp_status
);
    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             pend_q, pend_d;
    txn_status_e      stat_q, stat_d;

    always_comb begin
        phase_d   = phase_q;
        idx_d     = idx_q;
        pend_d    = pend_q;
        stat_d    = stat_q;
        accept    = 1'b0;
        clr_logs  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_valid = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                accept = 1'b1;
                if (beat_fire && beat_last) begin
                    phase_d = PH_VALIDATE;
                    idx_d   = '0;
                    pend_d  = 1'b0;
                end
            end
            PH_VALIDATE: begin
                if (rd_ovf || wr_ovf) begin
                    stat_d  = ST_OVERFLOW;
                    phase_d = PH_RESPOND;
                end else if (pend_q) begin
                    if (mem_rvalid) begin
                        pend_d = 1'b0;
                        if (mem_rdata != rd_entry.data) begin
                            stat_d  = ST_CONFLICT;
                            phase_d = PH_RESPOND;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                end else if (idx_q == rd_cnt) begin
                    idx_d = '0;
                    if (wr_cnt == '0) begin
                        stat_d  = ST_PASS;
                        phase_d = PH_RESPOND;
                    end else begin
                        phase_d = PH_WRITEBACK;
                    end
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = rd_entry.addr;
                    pend_d   = 1'b1;
                end
            end
            PH_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wr_entry.addr;
                mem_wdata = wr_entry.data;
                if (idx_q == IDX_W'(wr_cnt - 1'b1)) begin
                    stat_d  = ST_PASS;
                    phase_d = PH_RESPOND;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            PH_RESPOND: begin
                rsp_valid = 1'b1;
                if (rsp_ready) begin
                    clr_logs = 1'b1;
                    phase_d  = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            stat_q  <= ST_PASS;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            pend_q  <= pend_d;
            stat_q  <= stat_d;
        end
    end

    assign idx        = idx_q;
    assign rsp_status = stat_q;

endmodule

// File: rtl/txn_commit_unit.sv
module txn_commit_unit
    import txn_commit_pkg::*;
#(
    parameter int unsigned RD_DEPTH = 4,
    parameter int unsigned WR_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_status
);
    localparam int unsigned MAX_DEPTH = max_of(RD_DEPTH, WR_DEPTH);
    localparam int unsigned IDX_W     = $clog2(MAX_DEPTH + 1);

    logic             fire, clr_logs;
    logic [IDX_W-1:0] idx, rd_cnt, wr_cnt;
    logic             rd_ovf, wr_ovf;
    log_entry_t       in_entry, rd_entry, wr_entry;
    txn_status_e      status;

    assign fire       = req_valid && req_ready;
    assign in_entry   = '{addr: req_addr, data: req_data};
    assign rsp_status = status;

    txn_log_store #(.DEPTH(RD_DEPTH), .IDX_W(IDX_W)) u_rd_log (
        .clk(clk), .rst(rst), .clr(clr_logs),
        .push(fire && !req_kind), .push_entry(in_entry),
        .rd_idx(idx), .rd_entry(rd_entry),
        .count(rd_cnt), .overflow(rd_ovf)
    );

    txn_log_store #(.DEPTH(WR_DEPTH), .IDX_W(IDX_W)) u_wr_log (
        .clk(clk), .rst(rst), .clr(clr_logs),
        .push(fire && req_kind), .push_entry(in_entry),
        .rd_idx(idx), .rd_entry(wr_entry),
        .count(wr_cnt), .overflow(wr_ovf)
    );

    txn_commit_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .beat_fire(fire), .beat_last(req_last),
        .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
        .rd_ovf(rd_ovf), .wr_ovf(wr_ovf),
        .rd_entry(rd_entry), .wr_entry(wr_entry),
        .idx(idx), .accept(req_ready), .clr_logs(clr_logs),
        .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_status(status)
    );

endmodule

// File: rtl/txn_commit_checker.sv
module txn_commit_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       mem_req,
    input logic       mem_we,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [1:0] rsp_status
);
    logic any_mem_q, any_wr_q;

    always_ff @(posedge clk) begin
        if (rst || (rsp_valid && rsp_ready)) begin
            any_mem_q <= 1'b0;
            any_wr_q  <= 1'b0;
        end else begin
            if (mem_req)           any_mem_q <= 1'b1;
            if (mem_req && mem_we) any_wr_q  <= 1'b1;
        end
    end

    p_one_read_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !mem_req);

    p_conflict_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1) |-> !any_wr_q);

    p_overflow_no_access_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd2) |-> !any_mem_q);

    p_serial_sides_r8: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));

    p_quiet_when_ready_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req);

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

endmodule

bind txn_commit_unit txn_commit_checker u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status)
);

// File: tb/txn_commit_unit_test.sv
module txn_commit_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_kind = 1'b0, req_last = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_ready;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_rvalid;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;

    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = '0;
    logic [31:0] poke_data = '0;
    logic [31:0] store [256];
    int          n_rd = 0, n_wr = 0;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    txn_commit_unit uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status)
    );

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (poke_en) store[poke_addr] <= poke_data;
        if (mem_req) begin
            if (mem_we) begin
                store[mem_addr] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= store[mem_addr];
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic beat(input logic k, input logic [7:0] a, input logic [31:0] d, input logic l);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d; req_last = l;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_last = 1'b0;
    endtask

    task automatic take_rsp(output logic [1:0] st);
        while (!rsp_valid) @(negedge clk);
        st = rsp_status;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 req_ready", 32'(req_ready), 1);
        check("R10 rsp_valid", 32'(rsp_valid), 0);
        check("R10 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_pass();
        logic [1:0] st; int r0, w0;
        poke(8'd1, 32'd10); poke(8'd2, 32'd20);
        r0 = n_rd; w0 = n_wr;
        beat(1'b0, 8'd1, 32'd10, 1'b0);
        beat(1'b1, 8'd3, 32'd33, 1'b0);
        beat(1'b0, 8'd2, 32'd20, 1'b0);
        beat(1'b1, 8'd4, 32'd44, 1'b1);
        check("R8 ready low after last", 32'(req_ready), 0);
        take_rsp(st);
        check("R4 status pass", 32'(st), 0);
        check("R2 read count", 32'(n_rd - r0), 2);
        check("R4 write count", 32'(n_wr - w0), 2);
        check("R4 word 3", store[3], 33);
        check("R4 word 4", store[4], 44);
    endtask

    task automatic t_conflict();
        logic [1:0] st; int r0, w0;
        poke(8'd5, 32'd50); poke(8'd6, 32'd60); poke(8'd7, 32'd70); poke(8'd8, 32'd0);
        r0 = n_rd; w0 = n_wr;
        beat(1'b0, 8'd5, 32'd50, 1'b0);
        beat(1'b0, 8'd6, 32'd61, 1'b0);
        beat(1'b0, 8'd7, 32'd70, 1'b0);
        beat(1'b1, 8'd8, 32'd88, 1'b1);
        take_rsp(st);
        check("R3 status conflict", 32'(st), 1);
        check("R3 stops at mismatch", 32'(n_rd - r0), 2);
        check("R3 no writes", 32'(n_wr - w0), 0);
        check("R3 word 8 untouched", store[8], 0);
    endtask

    task automatic t_no_writes();
        logic [1:0] st; int w0;
        w0 = n_wr;
        beat(1'b0, 8'd1, 32'd10, 1'b1);
        take_rsp(st);
        check("R6 status pass", 32'(st), 0);
        check("R6 no writes", 32'(n_wr - w0), 0);
    endtask

    task automatic t_duplicate();
        logic [1:0] st;
        beat(1'b1, 8'd9, 32'd1, 1'b0);
        beat(1'b1, 8'd9, 32'd2, 1'b1);
        take_rsp(st);
        check("R5 status pass", 32'(st), 0);
        check("R5 later wins", store[9], 2);
    endtask

    task automatic t_rd_overflow();
        logic [1:0] st; int r0, w0;
        r0 = n_rd; w0 = n_wr;
        for (int i = 0; i < 5; i++) beat(1'b0, 8'(20 + i), 32'd0, i == 4);
        take_rsp(st);
        check("R7 read overflow status", 32'(st), 2);
        check("R7 no access", 32'(n_rd - r0 + n_wr - w0), 0);
    endtask

    task automatic t_wr_overflow();
        logic [1:0] st; int r0, w0;
        poke(8'd30, 32'd7);
        r0 = n_rd; w0 = n_wr;
        beat(1'b0, 8'd30, 32'd7, 1'b0);
        for (int i = 0; i < 5; i++) beat(1'b1, 8'd30, 32'(100 + i), i == 4);
        take_rsp(st);
        check("R7 write overflow status", 32'(st), 2);
        check("R7 no access", 32'(n_rd - r0 + n_wr - w0), 0);
        check("R7 word 30 untouched", store[30], 7);
    endtask

    task automatic t_hold();
        logic [1:0] st, first;
        beat(1'b0, 8'd1, 32'd99, 1'b1);
        while (!rsp_valid) @(negedge clk);
        first = rsp_status;
        repeat (3) @(negedge clk);
        check("R9 valid held", 32'(rsp_valid), 1);
        check("R9 status held", 32'(rsp_status), 32'(first));
        check("R8 ready low while pending", 32'(req_ready), 0);
        take_rsp(st);
        check("R3 stale read conflict", 32'(st), 1);
        check("R8 ready after handshake", 32'(req_ready), 1);
    endtask

    task automatic t_hidden_stores();
        logic [1:0] st;
        poke(8'd10, 32'd100);
        beat(1'b1, 8'd10, 32'd111, 1'b0);
        beat(1'b0, 8'd10, 32'd100, 1'b1);
        take_rsp(st);
        check("R1 interleaved pass", 32'(st), 0);
        check("R1 store applied after check", store[10], 111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_pass();
                t_conflict();
                t_no_writes();
                t_duplicate();
                t_rd_overflow();
                t_wr_overflow();
                t_hold();
                t_hidden_stores();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule